// File: doc/BRIEF.md
# Add/Subtract/Compare Unit with Corrected-Sign Carry

This block is the integer add, subtract and compare slice of a processor execute stage. It is purely combinational. It takes two operands (the destination value D and the source value S) and a three-bit operation code. It returns a result word, a carry flag C, a zero flag Z, an overflow indication, a result write-enable, and one update strobe for each flag.

For unsigned operations, C is the carry out of an add, or the borrow of a subtract. For signed operations, C is the sign the mathematical result really has, and that sign is correct even when the wrapped result overflows. Overflow is therefore not a separate flag bit. It is the difference between the wrapped result's top bit and C. A later test-overflow step can find it again by comparing a register's top bit against C.

Compare operations update the flags but never write the result. The two flag-write-enable inputs decide whether each flag strobe is raised at all.

Top module: `cs_arith_unit`

## Requirements
- R1: The op_sel codes are 0 = unsigned add, 1 = unsigned subtract, 2 = unsigned compare, 3 = signed add, 4 = signed subtract, 5 = signed compare. For code 0, result_o is (D+S) mod 2^32 and c_flag_o is the carry out of bit 31.
- R2: For codes 1 and 2, result_o is (D−S) mod 2^32, and c_flag_o is 1 exactly when D < S taken as unsigned numbers.
- R3: For code 3, result_o is (D+S) mod 2^32 and c_flag_o is 1 exactly when the true sum of D and S, both taken as two's-complement, is negative. ovf_o equals result_o[31] XOR c_flag_o for codes 3, 4 and 5.
- R4: For codes 4 and 5, result_o is (D−S) mod 2^32 and c_flag_o is 1 exactly when the true two's-complement difference D−S is negative.
- R5: For codes 0 to 5, z_flag_o is 1 exactly when result_o is all zeros.
- R6: For codes 2 and 5 (compares), res_we_o is 0. result_o still carries the difference.
- R7: For codes 0, 1, 3 and 4, res_we_o is 1.
- R8: c_upd_o equals c_wr_en_i for codes 0 to 5, and z_upd_o equals z_wr_en_i for codes 0 to 5.
- R9: For codes 6 and 7, result_o, res_we_o, c_flag_o, z_flag_o, ovf_o, c_upd_o and z_upd_o are all 0, whatever the enables and operands are.
- R10: For the unsigned codes 0, 1 and 2, ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_d | input | 32 | Destination operand D |
| opd_s | input | 32 | Source operand S |
| op_sel | input | 3 | Operation code |
| c_wr_en_i | input | 1 | Allows the C flag to be updated |
| z_wr_en_i | input | 1 | Allows the Z flag to be updated |
| result_o | output | 32 | Arithmetic result |
| res_we_o | output | 1 | Result write-enable |
| c_flag_o | output | 1 | Carry, borrow or corrected sign |
| z_flag_o | output | 1 | Result-is-zero flag |
| ovf_o | output | 1 | Signed overflow (result bit 31 differs from C) |
| c_upd_o | output | 1 | C flag update strobe |
| z_upd_o | output | 1 | Z flag update strobe |

## Verification
No register lies between any input and any output, so every result, flag, strobe and the overflow bit are due in the same cycle as the stimulus that causes them. The bench changes all inputs together on the falling clock edge. It samples 2 ns later, after the logic has settled and well before the next rising edge. Expected values come from 64-bit arithmetic in the bench: a wide unsigned sum or difference for the unsigned codes, and a sign-extended sum or difference whose sign gives C for the signed codes. The bench never uses the XOR formulas the design itself uses.

// File: rtl/cs_arith_pkg.sv
// Shared types for the add/subtract/compare unit: operation codes and
// the decoded control bundle. Assumes a 3-bit operation field.
package cs_arith_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_ADDS = 3'd3,
        OP_SUBS = 3'd4,
        OP_CMPS = 3'd5
    } op_code_e;

    typedef struct packed {
        logic valid;   // one of the six defined codes
        logic sub;     // subtract or compare
        logic sgn;     // signed flag semantics
        logic cmp;     // suppress result write
    } op_ctl_t;

endpackage

// File: rtl/cs_op_decode.sv
// Decodes the operation code into control bits. Codes outside the
// defined set yield an all-zero control bundle (valid = 0).
module cs_op_decode
    import cs_arith_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    output op_ctl_t         ctl
);

    // Map each operation code onto its control bits.
    always_comb begin
        ctl = '0;
        case (op_sel)
            OP_ADD:  ctl = '{valid: 1'b1, sub: 1'b0, sgn: 1'b0, cmp: 1'b0};
            OP_SUB:  ctl = '{valid: 1'b1, sub: 1'b1, sgn: 1'b0, cmp: 1'b0};
            OP_CMP:  ctl = '{valid: 1'b1, sub: 1'b1, sgn: 1'b0, cmp: 1'b1};
            OP_ADDS: ctl = '{valid: 1'b1, sub: 1'b0, sgn: 1'b1, cmp: 1'b0};
            OP_SUBS: ctl = '{valid: 1'b1, sub: 1'b1, sgn: 1'b1, cmp: 1'b0};
            OP_CMPS: ctl = '{valid: 1'b1, sub: 1'b1, sgn: 1'b1, cmp: 1'b1};
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/cs_addsub_core.sv
// One shared W+1-bit adder. A subtract is formed as D + ~S + 1, so
// bit W of raw_o is the carry out, which is 1 when there is no borrow.
// Assumes W >= 2.
module cs_addsub_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] opd_d,
    input  logic [W-1:0] opd_s,
    input  logic         sub,
    output logic [W:0]   raw_o,
    output logic         s_msb_eff_o
);

    logic [W-1:0] s_eff;

    // Invert the source operand when subtracting.
    always_comb s_eff = opd_s ^ {W{sub}};

    // Carry-in supplies the +1 that completes the two's-complement negation.
    always_comb raw_o = {1'b0, opd_d} + {1'b0, s_eff} + {{W{1'b0}}, sub};

    // Report the top bit of the operand actually fed to the adder.
    always_comb s_msb_eff_o = s_eff[W-1];

endmodule

// File: rtl/cs_flag_gen.sv
// Forms the gated result and the C, Z and overflow values from the raw
// adder output. Signed C is the sign the untruncated result really has.
// Overflow is defined only for signed operations.
module cs_flag_gen
    import cs_arith_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W:0]   raw,
    input  logic         d_msb,
    input  logic         s_msb_eff,
    input  op_ctl_t      ctl,
    output logic [W-1:0] result_o,
    output logic         c_o,
    output logic         z_o,
    output logic         ovf_o
);

    logic c_unsigned;
    logic c_signed;

    // Unsigned C: carry for an add, borrow (inverted carry) for a subtract.
    always_comb c_unsigned = raw[W] ^ ctl.sub;

    // Signed C: top bit of the sign-extended W+1-bit sum.
    always_comb c_signed = raw[W] ^ d_msb ^ s_msb_eff;

    // Gate the result and the flags by operation validity.
    always_comb begin
        result_o = ctl.valid ? raw[W-1:0] : '0;
        c_o      = ctl.valid & (ctl.sgn ? c_signed : c_unsigned);
        z_o      = ctl.valid & ~|raw[W-1:0];
        ovf_o    = ctl.valid & ctl.sgn & (raw[W-1] ^ c_signed);
    end

endmodule

// File: rtl/cs_arith_unit.sv
// Top of the add/subtract/compare unit. Purely combinational: decode,
// one shared adder, flag generation, and the write-enable and strobe
// gating. Compare operations update the flags but never write the result.
module cs_arith_unit
    import cs_arith_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    opd_d,
    input  logic [W-1:0]    opd_s,
    input  logic [OP_W-1:0] op_sel,
    input  logic            c_wr_en_i,
    input  logic            z_wr_en_i,
    output logic [W-1:0]    result_o,
    output logic            res_we_o,
    output logic            c_flag_o,
    output logic            z_flag_o,
    output logic            ovf_o,
    output logic            c_upd_o,
    output logic            z_upd_o
);

    op_ctl_t    ctl;
    logic [W:0] raw;
    logic       s_msb_eff;

    cs_op_decode u_dec (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    cs_addsub_core #(.W(W)) u_core (
        .opd_d       (opd_d),
        .opd_s       (opd_s),
        .sub         (ctl.sub),
        .raw_o       (raw),
        .s_msb_eff_o (s_msb_eff)
    );

    cs_flag_gen #(.W(W)) u_flags (
        .raw       (raw),
        .d_msb     (opd_d[W-1]),
        .s_msb_eff (s_msb_eff),
        .ctl       (ctl),
        .result_o  (result_o),
        .c_o       (c_flag_o),
        .z_o       (z_flag_o),
        .ovf_o     (ovf_o)
    );

    // Write the result only for defined operations that are not compares.
    always_comb res_we_o = ctl.valid & ~ctl.cmp;

    // Raise each flag strobe only when it is enabled and the code is defined.
    always_comb begin
        c_upd_o = ctl.valid & c_wr_en_i;
        z_upd_o = ctl.valid & z_wr_en_i;
    end

endmodule

// File: rtl/cs_arith_chk.sv
// Checker for cs_arith_unit. The block has no clock, so every check is an
// immediate assertion that relates the unit's ports once they settle.
module cs_arith_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opd_d,
    input logic [W-1:0] opd_s,
    input logic [2:0]   op_sel,
    input logic         c_wr_en_i,
    input logic         z_wr_en_i,
    input logic [W-1:0] result_o,
    input logic         res_we_o,
    input logic         c_flag_o,
    input logic         z_flag_o,
    input logic         ovf_o,
    input logic         c_upd_o,
    input logic         z_upd_o
);

    logic [W:0] wide_sum;

    // Reference carry-extended sum, used by the unsigned add check.
    always_comb wide_sum = {1'b0, opd_d} + {1'b0, opd_s};

    // Apply the port-level relations for each class of operation code.
    always_comb begin
        if (op_sel == 3'd0)
            assert_add_carry_R1: assert ({c_flag_o, result_o} == wide_sum);
        if (op_sel <= 3'd5)
            assert_zero_flag_R5: assert (z_flag_o == (result_o == '0));
        if (op_sel == 3'd2 || op_sel == 3'd5)
            assert_cmp_no_write_R6: assert (!res_we_o);
        if (op_sel == 3'd0 || op_sel == 3'd1 || op_sel == 3'd3 || op_sel == 3'd4)
            assert_write_R7: assert (res_we_o);
        if (op_sel <= 3'd5)
            assert_strobes_R8: assert (c_upd_o == c_wr_en_i && z_upd_o == z_wr_en_i);
        if (op_sel > 3'd5)
            assert_invalid_quiet_R9: assert (result_o == '0 && !res_we_o && !c_flag_o
                && !z_flag_o && !ovf_o && !c_upd_o && !z_upd_o);
        if (op_sel >= 3'd3 && op_sel <= 3'd5)
            assert_ovf_relation_R3: assert (ovf_o == (result_o[W-1] ^ c_flag_o));
        if (op_sel <= 3'd2)
            assert_no_overflow_R10: assert (!ovf_o);
    end

endmodule

bind cs_arith_unit cs_arith_chk #(.W(W)) u_chk (
    .opd_d     (opd_d),
    .opd_s     (opd_s),
    .op_sel    (op_sel),
    .c_wr_en_i (c_wr_en_i),
    .z_wr_en_i (z_wr_en_i),
    .result_o  (result_o),
    .res_we_o  (res_we_o),
    .c_flag_o  (c_flag_o),
    .z_flag_o  (z_flag_o),
    .ovf_o     (ovf_o),
    .c_upd_o   (c_upd_o),
    .z_upd_o   (z_upd_o)
);

// File: tb/sim_cs_arith_unit.sv
// Directed bench for cs_arith_unit. Inputs change on the falling edge and
// outputs are sampled 2 ns later, because the unit has no register stage.
module sim_cs_arith_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opd_d = '0;
    logic [31:0] opd_s = '0;
    logic [2:0]  op_sel = 3'd6;
    logic        c_wr_en_i = 1'b0;
    logic        z_wr_en_i = 1'b0;
    logic [31:0] result_o;
    logic        res_we_o, c_flag_o, z_flag_o, ovf_o, c_upd_o, z_upd_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cs_arith_unit u0 (
        .opd_d     (opd_d),
        .opd_s     (opd_s),
        .op_sel    (op_sel),
        .c_wr_en_i (c_wr_en_i),
        .z_wr_en_i (z_wr_en_i),
        .result_o  (result_o),
        .res_we_o  (res_we_o),
        .c_flag_o  (c_flag_o),
        .z_flag_o  (z_flag_o),
        .ovf_o     (ovf_o),
        .c_upd_o   (c_upd_o),
        .z_upd_o   (z_upd_o)
    );

    // Record one comparison of an actual value against an expected value.
    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Apply one operation, compute the expected outputs from plain
    // arithmetic, and check every output against them.
    task automatic run_op(input logic [2:0] op, input logic [31:0] d,
                          input logic [31:0] s, input logic cwe, input logic zwe,
                          input string req);
        logic        valid, sgn, sub, cmp;
        logic [63:0] wide;
        longint      sres;
        logic [31:0] e_res;
        logic        e_c, e_z, e_ovf;
        valid = (op <= 3'd5);
        sgn   = (op >= 3'd3) && valid;
        sub   = (op == 3'd1 || op == 3'd2 || op == 3'd4 || op == 3'd5);
        cmp   = (op == 3'd2 || op == 3'd5);
        if (!valid) begin
            e_res = '0; e_c = 1'b0;
        end else if (sgn) begin
            sres  = sub ? (longint'($signed(d)) - longint'($signed(s)))
                        : (longint'($signed(d)) + longint'($signed(s)));
            e_res = sres[31:0];
            e_c   = (sres < 0);
        end else if (sub) begin
            e_res = d - s;
            e_c   = (d < s);
        end else begin
            wide  = {32'd0, d} + {32'd0, s};
            e_res = wide[31:0];
            e_c   = wide[32];
        end
        e_z   = valid && (e_res == 32'd0);
        e_ovf = sgn && (e_res[31] != e_c);

        @(negedge clk);
        op_sel = op; opd_d = d; opd_s = s; c_wr_en_i = cwe; z_wr_en_i = zwe;
        #2;
        chk(req, "result", result_o, e_res);
        chk(req, "C", {31'd0, c_flag_o}, {31'd0, e_c});
        chk(valid ? "R5" : "R9", "Z", {31'd0, z_flag_o}, {31'd0, e_z});
        chk(!valid ? "R9" : (cmp ? "R6" : "R7"), "res_we",
            {31'd0, res_we_o}, {31'd0, valid && !cmp});
        chk(valid ? "R8" : "R9", "c_upd", {31'd0, c_upd_o}, {31'd0, valid && cwe});
        chk(valid ? "R8" : "R9", "z_upd", {31'd0, z_upd_o}, {31'd0, valid && zwe});
        chk(sgn ? "R3" : (valid ? "R10" : "R9"), "ovf", {31'd0, ovf_o}, {31'd0, e_ovf});
    endtask

    // Idle state right after reset: an undefined code leaves every output quiet.
    task automatic test_reset_state();
        #2;
        chk("R9", "idle result", result_o, 32'd0);
        chk("R9", "idle we", {31'd0, res_we_o}, 32'd0);
    endtask

    // R1: unsigned add, with and without a carry out.
    task automatic test_add();
        run_op(3'd0, 32'd5, 32'd7, 1'b1, 1'b1, "R1");
        run_op(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1, "R1");
        run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, "R1");
        run_op(3'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, "R1");
    endtask

    // R2: unsigned subtract and compare, with and without a borrow.
    task automatic test_sub_cmp();
        run_op(3'd1, 32'd10, 32'd3, 1'b1, 1'b1, "R2");
        run_op(3'd1, 32'd3, 32'd10, 1'b1, 1'b1, "R2");
        run_op(3'd2, 32'd9, 32'd9, 1'b1, 1'b1, "R2");
        run_op(3'd2, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, "R2");
    endtask

    // R3: signed add, including positive and negative overflow.
    task automatic test_adds();
        run_op(3'd3, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, "R3");
        run_op(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, "R3");
        run_op(3'd3, 32'hFFFF_FFFE, 32'd1, 1'b1, 1'b1, "R3");
        run_op(3'd3, 32'd4, 32'hFFFF_FFFC, 1'b1, 1'b1, "R3");
    endtask

    // R4: signed subtract and compare, including overflow in both directions.
    task automatic test_subs_cmps();
        run_op(3'd4, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R4");
        run_op(3'd4, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, "R4");
        run_op(3'd5, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1, "R4");
        run_op(3'd5, 32'd1, 32'd1, 1'b1, 1'b1, "R4");
    endtask

    // R8: flag strobes follow their enables on defined codes.
    task automatic test_enables();
        run_op(3'd0, 32'd1, 32'd2, 1'b0, 1'b1, "R8");
        run_op(3'd4, 32'd1, 32'd2, 1'b1, 1'b0, "R8");
        run_op(3'd2, 32'd1, 32'd2, 1'b0, 1'b0, "R8");
    endtask

    // R9: undefined codes stay quiet even when the operands would give a zero result.
    task automatic test_invalid();
        run_op(3'd6, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1, "R9");
        run_op(3'd7, 32'd0, 32'd0, 1'b1, 1'b1, "R9");
    endtask

    // Pseudo-random operands across all eight codes.
    task automatic test_sweep();
        logic [31:0] a = 32'h1234_5678;
        logic [31:0] b = 32'h9ABC_DEF0;
        for (int i = 0; i < 200; i++) begin
            a = {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]};
            b = b * 32'd1664525 + 32'd1013904223;
            run_op(i[2:0], a, (i % 11 == 0) ? a : b, i[3], i[4], "R1/R2/R3/R4 sweep");
        end
    endtask

    // Watchdog: count an expiry as a failure and still print the summary line.
    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Main sequence: reset, the scenarios, then the summary line.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_add();
        test_sub_cmp();
        test_adds();
        test_subs_cmps();
        test_enables();
        test_invalid();
        test_sweep();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule